// File: doc/BRIEF.md
# Reloading Countdown Timer with Flag and Interrupt

This block is an 8-bit down-counter that advances on one of four externally supplied tick strobes: 4096 Hz, 64 Hz, 1 Hz and one per minute. Software writes a start value n. The counter steps down once per selected tick from n to 1. On the next tick it reloads n and marks the end of a countdown period. The period is therefore n divided by the source frequency.

Each countdown end sets a sticky timer flag. Software clears the flag by writing a zero to it. The active-low interrupt line works in one of two ways. In level mode it follows the flag. In pulse mode it gives a low pulse of fixed length at each countdown end. Both modes are gated by an interrupt enable. The pulse length depends on the source, and at the two fastest sources also on whether n is one. The length is timed with an 8192 Hz reference strobe.

Two registers are reachable through a single-cycle write port and a combinational read port. Address 0 is the control word. Address 1 is the count.

Top module: `tmr_top`

## Requirements
- R1: After reset the control word reads 0x06 (source code 11, all other bits 0), the count reads 0x00 and `irq_n` is high. Control word layout: bit 0 run, bits 2:1 source code, bit 3 interrupt enable, bit 4 pulse mode, bit 5 flag.
- R2: Source code 00 selects `src_tick[0]` (4096 Hz), 01 selects `src_tick[1]` (64 Hz), 10 selects `src_tick[2]` (1 Hz) and 11 selects `src_tick[3]` (1/60 Hz). Ticks on the unselected inputs do not move the count.
- R3: While running, each selected tick decrements the count. A tick that arrives at count 1 reloads n instead, so one period is n ticks.
- R4: With run at 0, or with n equal to 0, the count holds and the flag never sets.
- R5: The flag sets in the cycle after the tick that ends a countdown.
- R6: A control write with bit 5 at 0 clears the flag. A control write with bit 5 at 1 leaves the flag as it was.
- R7: In level mode (bit 4 = 0), `irq_n` is low exactly when the flag and the interrupt enable are both 1.
- R8: In pulse mode, a countdown end drives `irq_n` low in the same cycle that the flag sets, but only while the interrupt enable is 1. After the pulse, `irq_n` returns high even though the flag stays set.
- R9: With the 4096 Hz source, the pulse lasts 1 reference tick when n = 1 and 2 reference ticks when n > 1.
- R10: With the 64 Hz source, the pulse lasts 64 reference ticks when n = 1 and 128 reference ticks when n > 1.
- R11: With the 1 Hz and the 1/60 Hz sources, the pulse always lasts 128 reference ticks.
- R12: A read of address 1 returns the current count. A write to address 1 loads both n and the current count, which restarts the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | One-cycle tick strobes, indexed by source code |
| ref_tick | input | 1 | 8192 Hz one-cycle strobe used to time pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 count |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 count |
| rd_data | output | 8 | Read data for `rd_addr` |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The countdown is first driven with ticks on the wrong input, then with ticks on the right input. This shows that the source decode is correct and that the reload lands on n rather than on 0. Start values of 0, 1, 2, 3 and 5 are used. They separate a stopped timer, the single-tick period, and the general case, and one of them is interrupted by a reload write in the middle of a period. Pulse lengths are measured in reference ticks for every source and for both the n = 1 and n > 1 cases. This catches a width table that is swapped between n = 1 and n > 1 or between sources. Runs with the enable off confirm the gating in both modes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    SRC_4096 = 2'b00,
    SRC_64   = 2'b01,
    SRC_1    = 2'b10,
    SRC_MIN  = 2'b11
  } src_e;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CNT  = 1'b1;

  localparam int B_RUN   = 0;
  localparam int B_SRC_L = 1;
  localparam int B_SRC_H = 2;
  localparam int B_IE    = 3;
  localparam int B_PMODE = 4;
  localparam int B_FLAG  = 5;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
  parameter int N_SRC = 4,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] ticks,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = ticks[g] & (sel == SEL_W'(g));
  end

  assign tick = |hit;
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cur,
  output logic [CNT_W-1:0] rld,
  output logic             expire
);
  logic [CNT_W-1:0] cur_q, cur_d, rld_q, rld_d;
  logic             step;

  assign step   = run & tick & ~load;
  assign expire = step & (cur_q == CNT_W'(1));

  always_comb begin
    cur_d = cur_q;
    rld_d = rld_q;
    if (load) begin
      cur_d = load_val;
      rld_d = load_val;
    end else if (expire) begin
      cur_d = rld_q;
    end else if (step && cur_q > CNT_W'(1)) begin
      cur_d = cur_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      rld_q <= '0;
    end else begin
      cur_q <= cur_d;
      rld_q <= rld_d;
    end
  end

  assign cur = cur_q;
  assign rld = rld_q;
endmodule

// File: rtl/tmr_irq_pulse.sv
module tmr_irq_pulse #(
  parameter int REF_HZ = 8192,
  localparam int W_FAST_N1 = REF_HZ / 8192,
  localparam int W_FAST    = REF_HZ / 4096,
  localparam int W_MID_N1  = REF_HZ / 128,
  localparam int W_SLOW    = REF_HZ / 64,
  localparam int PW_W      = $clog2(W_SLOW + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  tmr_pkg::src_e       src,
  input  logic                n_is_one,
  input  logic                ref_tick,
  output logic                active
);
  import tmr_pkg::*;

  logic            act_q, act_d;
  logic [PW_W-1:0] cnt_q, cnt_d, wid_q, wid_d, wid_sel;

  always_comb begin
    unique case (src)
      SRC_4096: wid_sel = n_is_one ? PW_W'(W_FAST_N1) : PW_W'(W_FAST);
      SRC_64:   wid_sel = n_is_one ? PW_W'(W_MID_N1)  : PW_W'(W_SLOW);
      default:  wid_sel = PW_W'(W_SLOW);
    endcase
  end

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    wid_d = wid_q;
    if (start) begin
      act_d = 1'b1;
      cnt_d = '0;
      wid_d = wid_sel;
    end else if (act_q && ref_tick) begin
      if (cnt_q == wid_q - PW_W'(1)) act_d = 1'b0;
      else                           cnt_d = cnt_q + PW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      wid_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      wid_q <= wid_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/tmr_top.sv
module tmr_top #(
  parameter int N_SRC  = 4,
  parameter int REF_HZ = 8192,
  localparam int CNT_W = tmr_pkg::DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_tick,
  input  logic             ref_tick,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_n
);
  import tmr_pkg::*;

  logic rst_s1, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s  <= rst_s1;
    end
  end

  logic       ctrl_wr, cnt_load;
  logic       ctrl_run, ctrl_ie, ctrl_pmode, flag_q;
  src_e       ctrl_src;
  logic       run_d, ie_d, pmode_d, flag_d;
  src_e       src_d;
  logic       wr_flag;
  logic       sel_tick, expire, pulse_act;
  logic [CNT_W-1:0] cur_cnt, rld_cnt;

  assign ctrl_wr  = wr_en & (wr_addr == ADDR_CTRL);
  assign cnt_load = wr_en & (wr_addr == ADDR_CNT);
  assign wr_flag  = wr_data[B_FLAG];

  tmr_tick_sel #(.N_SRC(N_SRC)) i_sel (
    .ticks(src_tick), .sel(ctrl_src), .tick(sel_tick)
  );

  tmr_down_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_s), .tick(sel_tick), .run(ctrl_run),
    .load(cnt_load), .load_val(wr_data), .cur(cur_cnt), .rld(rld_cnt),
    .expire(expire)
  );

  tmr_irq_pulse #(.REF_HZ(REF_HZ)) i_pulse (
    .clk(clk), .rst_n(rst_s), .start(expire), .src(ctrl_src),
    .n_is_one(rld_cnt == CNT_W'(1)), .ref_tick(ref_tick), .active(pulse_act)
  );

  always_comb begin
    run_d   = ctrl_run;
    ie_d    = ctrl_ie;
    pmode_d = ctrl_pmode;
    src_d   = ctrl_src;
    flag_d  = flag_q;
    if (ctrl_wr) begin
      run_d   = wr_data[B_RUN];
      ie_d    = wr_data[B_IE];
      pmode_d = wr_data[B_PMODE];
      src_d   = src_e'(wr_data[B_SRC_H:B_SRC_L]);
      if (!wr_flag) flag_d = 1'b0;
    end
    if (expire) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_run   <= 1'b0;
      ctrl_ie    <= 1'b0;
      ctrl_pmode <= 1'b0;
      ctrl_src   <= SRC_MIN;
      flag_q     <= 1'b0;
    end else begin
      ctrl_run   <= run_d;
      ctrl_ie    <= ie_d;
      ctrl_pmode <= pmode_d;
      ctrl_src   <= src_d;
      flag_q     <= flag_d;
    end
  end

  always_comb begin
    if (rd_addr == ADDR_CNT) rd_data = cur_cnt;
    else rd_data = CNT_W'({flag_q, ctrl_pmode, ctrl_ie, ctrl_src, ctrl_run});
  end

  assign irq_n = ~(ctrl_ie & (ctrl_pmode ? pulse_act : flag_q));
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_n,
  input logic             expire,
  input logic             flag_q,
  input logic             pulse_act,
  input logic             pmode,
  input logic             irq_en,
  input logic             run,
  input logic             cnt_load,
  input logic             ctrl_wr,
  input logic             wr_flag,
  input logic [CNT_W-1:0] cur,
  input logic [CNT_W-1:0] rld
);
  // R5
  flag_pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (flag_q && pulse_act));

  // R7
  level_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pmode && flag_q && irq_en) |-> !irq_n);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> irq_n);

  // R8
  pulse_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && pmode && irq_en && !ctrl_wr) |=> !irq_n);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_load) |=> $stable(cur));

  // R3
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur <= rld);

  // R6
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(ctrl_wr && !wr_flag)) |=> flag_q);
endmodule

bind tmr_top tmr_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_s), .irq_n(irq_n), .expire(expire),
  .flag_q(flag_q), .pulse_act(pulse_act), .pmode(ctrl_pmode),
  .irq_en(ctrl_ie), .run(ctrl_run), .cnt_load(cnt_load),
  .ctrl_wr(ctrl_wr), .wr_flag(wr_flag), .cur(cur_cnt), .rld(rld_cnt)
);

// File: tb/test_tmr_top.sv
module test_tmr_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] src_tick;
  logic       ref_tick;
  logic       wr_en, wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       irq_n;
  int         n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  tmr_top i_tmr_top (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ref_tick(ref_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic stick(input int s);
    @(negedge clk); src_tick[s] = 1'b1;
    @(negedge clk); src_tick = '0;
  endtask

  task automatic rtick();
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1'b0, d); check("R1 ctrl", d, 8'h06);
    rd(1'b1, d); check("R1 count", d, 0);
    check("R1 irq_n", irq_n, 1);
  endtask

  task automatic t_count();
    logic [7:0] d;
    wr(1'b1, 8'd3);
    rd(1'b1, d); check("R12 load readback", d, 3);
    wr(1'b0, 8'h05);
    stick(0); stick(1); stick(3);
    rd(1'b1, d); check("R2 unselected ticks", d, 3);
    stick(2);
    rd(1'b1, d); check("R3 first step", d, 2);
    rd(1'b0, d); check("R5 no early flag", d, 8'h05);
    stick(2);
    rd(1'b1, d); check("R3 at one", d, 1);
    stick(2);
    rd(1'b1, d); check("R3 reload", d, 3);
    rd(1'b0, d); check("R5 flag set", d, 8'h25);
  endtask

  task automatic t_flag();
    logic [7:0] d;
    wr(1'b0, 8'h25);
    rd(1'b0, d); check("R6 write one keeps", d, 8'h25);
    wr(1'b0, 8'h05);
    rd(1'b0, d); check("R6 write zero clears", d, 8'h05);
  endtask

  task automatic t_level();
    wr(1'b1, 8'd1);
    wr(1'b0, 8'h0D);
    check("R7 idle high", irq_n, 1);
    stick(2);
    check("R7 low with flag", irq_n, 0);
    wr(1'b0, 8'h25);
    check("R7 enable off", irq_n, 1);
    wr(1'b0, 8'h2D);
    check("R7 enable back on", irq_n, 0);
    wr(1'b0, 8'h0D);
    check("R7 flag cleared", irq_n, 1);
  endtask

  task automatic t_stop();
    logic [7:0] d;
    wr(1'b0, 8'h05);
    wr(1'b1, 8'd0);
    stick(2); stick(2);
    rd(1'b1, d); check("R4 n zero count", d, 0);
    rd(1'b0, d); check("R4 n zero flag", d, 8'h05);
    wr(1'b1, 8'd5);
    wr(1'b0, 8'h04);
    stick(2); stick(2);
    rd(1'b1, d); check("R4 run off", d, 5);
  endtask

  task automatic t_restart();
    logic [7:0] d;
    wr(1'b0, 8'h05);
    stick(2); stick(2);
    rd(1'b1, d); check("R12 midway", d, 3);
    wr(1'b1, 8'd2);
    rd(1'b1, d); check("R12 reloaded", d, 2);
    stick(2);
    rd(1'b0, d); check("R12 no flag yet", d, 8'h05);
    stick(2);
    rd(1'b0, d); check("R12 period from new n", d, 8'h25);
    rd(1'b1, d); check("R12 reload new n", d, 2);
    wr(1'b0, 8'h05);
  endtask

  task automatic t_pulse(string req, input int s, input int n, input int exp_w);
    logic [7:0] d;
    int w;
    wr(1'b0, 8'(8'h19 | (s << 1)));
    wr(1'b1, 8'(n));
    for (int i = 0; i < n; i++) stick(s);
    check({req, " pulse low"}, irq_n, 0);
    rd(1'b0, d); check({req, " flag with pulse"}, d[5], 1);
    w = 0;
    for (int k = 1; k <= 300; k++) begin
      rtick();
      if (irq_n) begin w = k; break; end
    end
    check({req, " width"}, w, exp_w);
    rd(1'b0, d); check("R8 flag stays", d[5], 1);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_gate();
    logic [7:0] d;
    wr(1'b0, 8'h15);
    wr(1'b1, 8'd1);
    stick(2);
    check("R8 gated high", irq_n, 1);
    rd(1'b0, d); check("R8 gated flag", d[5], 1);
    wr(1'b0, 8'h00);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    n_fail++; n_run++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_tick = '0; ref_tick = 1'b0;
    wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_count();
    t_flag();
    t_level();
    t_stop();
    t_restart();
    t_pulse("R9 n1", 0, 1, 1);
    t_pulse("R9 n3", 0, 3, 2);
    t_pulse("R10 n1", 1, 1, 64);
    t_pulse("R10 n2", 1, 2, 128);
    t_pulse("R11 1Hz", 2, 1, 128);
    t_pulse("R11 min", 3, 2, 128);
    t_gate();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule